// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers five active-low interrupt request lines into one CPU interrupt request. One line comes from a serial UART and four come from expansion-slot devices. Each line first passes through a synchroniser clocked by the CPU clock. The block then shows the synchronised requests as a live status byte. Software reads this byte to find which source needs service, and reading it never changes anything. A request goes away only when its source releases its own line.

A second byte, the mask, can be written and read back. It enables each source on its own. The single active-low output to the CPU falls whenever at least one source is both requesting and enabled. Two decoded chip selects choose the register, and `rdEn` and `wrEn` qualify the access. The bit layout is fixed. The UART sits at bit 7, expansion devices 4, 3, 2 and 1 sit at bits 6, 5, 4 and 3, and bits 2 to 0 are spare.

Top module: `irqStatusMask`

## Requirements
- R1: A status read (`statusSel`=1, `rdEn`=1) returns bit 7 = 1 while `uartIrqN` is low. It returns bit 3+k = 1 while `devIrqN[k]` is low, for k = 0..3, where `devIrqN[0]` is device 1.
- R2: Reading the status register clears nothing. A status bit stays 1 across any number of reads for as long as its line stays low, and goes to 0 only after the line returns high.
- R3: A write with `maskSel`=1, `wrEn`=1 and `statusSel`=0 loads the mask on that clock edge. A 1 enables a source and a 0 disables it. A read with `maskSel`=1, `statusSel`=0 and `rdEn`=1 returns the mask currently held.
- R4: While `rstN` is low, and right after it is released, the mask is 0x00, the status reads 0x00 whatever the request lines do, and `cpuIrqN` is 1.
- R5: Bits 2..0 read 0 in both registers. A value written into those bits is dropped, so writing 0xFF to the mask reads back as 0xF8.
- R6: `cpuIrqN` is registered. After each clock edge it is 0 exactly when, just before that edge, some status bit and the matching mask bit were both 1.
- R7: A change on a request line shows up in the status byte after the second rising clock edge following the change (SYNC_STAGES = 2). It does not show up after the first edge.
- R8: `rdData` is 0x00 when `rdEn` is 0 or when neither select is active. When both selects are active, a read returns the status byte.
- R9: The status register is read-only. A write with `statusSel`=1 changes nothing, even if `maskSel` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| statusSel | input | 1 | Decoded select for the status register |
| maskSel | input | 1 | Decoded select for the mask register |
| rdEn | input | 1 | Read qualifier |
| wrEn | input | 1 | Write qualifier |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| uartIrqN | input | 1 | UART request, active low, asynchronous |
| devIrqN | input | 4 | Expansion device requests, active low, bit 0 = device 1 |
| cpuIrqN | output | 1 | Combined CPU interrupt request, active low |

## Verification
The bench builds the block with its default two-stage synchroniser. This makes the exact two-edge latency from a line change to the status byte visible, and checkable cycle by cycle, against a model that keeps a short history of line samples. With this depth the register stage on `cpuIrqN` adds a third edge of delay. It also lets a mask write and a line change land on the same edge, so the bench can see which value of each the request output uses.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int DATA_W   = 8;
  localparam int NUM_DEV  = 4;
  localparam int NUM_SRC  = NUM_DEV + 1;
  localparam int UART_BIT = 7;
  localparam int DEV_BASE = 3;

  typedef struct packed {
    logic maskWr;
    logic rdStatus;
    logic rdMask;
  } irqStrobeT;
endpackage

// File: rtl/irqSync.sv
module irqSync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] lineRawN,
  output logic [WIDTH-1:0] lineSyncN
);
  localparam int CW = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '1;
        else       stageQ[s] <= lineRawN;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '1;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign lineSyncN = stageQ[STAGES-1];

  // Edges seen since reset release, saturating; gates the latency check.
  logic [CW-1:0] warmQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      warmQ <= '0;
    else if (warmQ != CW'(STAGES))  warmQ <= warmQ + 1'b1;
  end

  if (STAGES == 2) begin : g_chk2
    // R7: line value reaches the output exactly two edges later
    a_r7_sync_latency: assert property (@(posedge clk) disable iff (!rstN)
      (warmQ == CW'(STAGES)) |-> (lineSyncN == $past(lineRawN, 2)));
  end
endmodule

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      statusSel,
  input  logic      maskSel,
  input  logic      rdEn,
  input  logic      wrEn,
  output irqStrobeT strb
);
  always_comb begin
    strb.rdStatus = rdEn & statusSel;
    strb.rdMask   = rdEn & maskSel & ~statusSel;
    strb.maskWr   = wrEn & maskSel & ~statusSel;
  end

  // R8: at most one register drives the read bus
  a_r8_single_reader: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdStatus, strb.rdMask}));
  // R9: a status selection never produces a mask load
  a_r9_status_readonly: assert property (@(posedge clk) disable iff (!rstN)
    statusSel |-> !strb.maskWr);
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobeT          strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] lineSyncN,
  output logic [DATA_W-1:0]  rdData,
  output logic               cpuIrqN
);
  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'(((1 << NUM_DEV) - 1) << DEV_BASE) | DATA_W'(1 << UART_BIT);

  logic [DATA_W-1:0] statusBits;
  logic [DATA_W-1:0] maskQ;
  logic              cpuIrqNQ;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == UART_BIT) begin : g_uart
      assign statusBits[b] = ~lineSyncN[NUM_SRC-1];
    end else if (b >= DEV_BASE && b < DEV_BASE + NUM_DEV) begin : g_dev
      assign statusBits[b] = ~lineSyncN[b-DEV_BASE];
    end else begin : g_spare
      assign statusBits[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.maskWr) maskQ <= wrData & USED_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuIrqNQ <= 1'b1;
    else       cpuIrqNQ <= ~|(statusBits & maskQ);
  end

  assign cpuIrqN = cpuIrqNQ;

  always_comb begin
    if (strb.rdStatus)    rdData = statusBits;
    else if (strb.rdMask) rdData = maskQ;
    else                  rdData = '0;
  end

  // R3: a load takes the written value on the used bits
  a_r3_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWr |=> (maskQ == ($past(wrData) & USED_MASK)));
  // R3: without a load the mask keeps its value
  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.maskWr |=> $stable(maskQ));
  // R6: an enabled, pending source pulls the request low on the next edge
  a_r6_irq_assert: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusBits & maskQ)) |=> !cpuIrqN);
  // R6: no enabled, pending source leaves the request high
  a_r6_irq_release: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusBits & maskQ)) |=> cpuIrqN);
  // R5: spare bits never appear on the read bus
  a_r5_spare_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DEV_BASE-1:0] == '0);
endmodule

// File: rtl/irqStatusMask.sv
module irqStatusMask
  import irqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               statusSel,
  input  logic               maskSel,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               uartIrqN,
  input  logic [NUM_DEV-1:0] devIrqN,
  output logic               cpuIrqN
);
  irqStrobeT          strb;
  logic [NUM_SRC-1:0] lineSyncN;

  irqSync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_SRC)) i_sync (
    .clk(clk), .rstN(rstN),
    .lineRawN({uartIrqN, devIrqN}),
    .lineSyncN(lineSyncN)
  );

  irqCtrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .statusSel(statusSel), .maskSel(maskSel),
    .rdEn(rdEn), .wrEn(wrEn),
    .strb(strb)
  );

  irqDatapath i_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .wrData(wrData),
    .lineSyncN(lineSyncN),
    .rdData(rdData), .cpuIrqN(cpuIrqN)
  );
endmodule

// File: tb/test_irqStatusMask.sv
module test_irqStatusMask;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       statusSel = 1'b0, maskSel = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       uartIrqN = 1'b1;
  logic [3:0] devIrqN = 4'hF;
  logic [7:0] rdData;
  logic       cpuIrqN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  irqStatusMask #(.SYNC_STAGES(S)) i_irqStatusMask (
    .clk(clk), .rstN(rstN), .statusSel(statusSel), .maskSel(maskSel),
    .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .uartIrqN(uartIrqN), .devIrqN(devIrqN), .cpuIrqN(cpuIrqN)
  );

  always #2 clk = ~clk;

  // Reference model: history of line samples, mask, request flag
  logic [4:0] hist[$] = '{5'h1F, 5'h1F};
  logic [7:0] mMask = 8'h00;
  logic       mIrqN = 1'b1;

  function automatic logic [7:0] mStatus();
    return {~hist[0], 3'b000};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist = '{5'h1F, 5'h1F};
      mMask = 8'h00;
      mIrqN = 1'b1;
    end else begin
      mIrqN = ~|(mStatus() & mMask);
      if (wrEn && maskSel && !statusSel) mMask = wrData & 8'hF8;
      hist.push_back({uartIrqN, devIrqN});
      void'(hist.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    cycles++;
    if (rdEn && statusSel)    chk("R1/R2 status", rdData, mStatus());
    else if (rdEn && maskSel) chk("R3 mask", rdData, mMask);
    else                      chk("R8 idle bus", rdData, 8'h00);
    chk("R6 cpuIrqN", {7'd0, cpuIrqN}, {7'd0, mIrqN});
  end

  task automatic step(input logic ss, ms, re, we, input logic [7:0] wd,
                      input logic u, input logic [3:0] d);
    @(negedge clk);
    statusSel = ss; maskSel = ms; rdEn = re; wrEn = we; wrData = wd;
    uartIrqN = u; devIrqN = d;
  endtask

  initial begin
    // Reset with every line requesting
    step(1, 0, 1, 0, 8'h00, 0, 4'h0);
    repeat (4) @(negedge clk);
    chk("R4 status in reset", rdData, 8'h00);
    chk("R4 irq in reset", {7'd0, cpuIrqN}, 8'h01);
    rstN = 1'b1;
    step(0, 1, 1, 0, 8'h00, 1, 4'hF);
    @(negedge clk);
    chk("R4 mask after reset", rdData, 8'h00);

    // R1 bit mapping, R2 non-destructive reads
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 1, 0, 8'h00, 1, ~(4'b1 << k));
      repeat (4) @(negedge clk);
      chk("R1 device bit", rdData, 8'h08 << k);
      repeat (3) @(negedge clk);
      chk("R2 still set", rdData, 8'h08 << k);
    end
    step(1, 0, 1, 0, 8'h00, 0, 4'hF);
    repeat (3) @(negedge clk);
    chk("R1 uart bit", rdData, 8'h80);
    step(1, 0, 1, 0, 8'h00, 1, 4'hF);
    repeat (3) @(negedge clk);
    chk("R2 clears on release", rdData, 8'h00);

    // R7 latency: device 1 low
    step(1, 0, 1, 0, 8'h00, 1, 4'hE);
    @(posedge clk); #1 chk("R7 after first edge", rdData, 8'h00);
    @(posedge clk); #1 chk("R7 after second edge", rdData, 8'h08);

    // R5 spare bits dropped, R3 read back
    step(0, 1, 0, 1, 8'hFF, 1, 4'hF);
    step(0, 1, 1, 0, 8'h00, 1, 4'hF);
    @(negedge clk);
    chk("R5 mask readback", rdData, 8'hF8);

    // R6: enable device 2 only
    step(0, 1, 0, 1, 8'h10, 1, 4'hF);
    step(0, 0, 0, 0, 8'h00, 1, 4'hE);
    repeat (4) @(negedge clk);
    chk("R6 masked source", {7'd0, cpuIrqN}, 8'h01);
    step(0, 0, 0, 0, 8'h00, 1, 4'hC);
    repeat (4) @(negedge clk);
    chk("R6 enabled source", {7'd0, cpuIrqN}, 8'h00);

    // R9 write with status select ignored; R8 both selects read status
    step(1, 1, 0, 1, 8'h00, 1, 4'hC);
    step(0, 1, 1, 0, 8'h00, 1, 4'hC);
    @(negedge clk);
    chk("R9 mask unchanged", rdData, 8'h10);
    step(1, 1, 1, 0, 8'h00, 1, 4'hC);
    @(negedge clk);
    chk("R8 status priority", rdData, 8'h18);

    // Random traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom;
      step(r[0], r[1], r[2], r[3] & r[4], r[15:8],
           (r[19:16] != 0), (r[23:20] == 0) ? r[27:24] : devIrqN);
    end
    step(0, 0, 0, 0, 8'h00, 1, 4'hF);
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule